// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic core of a small accumulator machine. It holds two 8-bit accumulators, A and B, and an 8-bit condition register. A one-cycle `start` strobe with an opcode and an operand runs one operation. The operation can be add, subtract, AND, OR, XOR, complement or a one-bit shift on either accumulator. It can also be an unsigned 8x8 multiply of A by B, or a 16-bit add to the pair A:B, called D. The result is written back, the status flags are updated, and `done` pulses for one cycle.

The datapath is a single 8-bit lane. The 16-bit add therefore runs as two passes. The low byte (B) goes first and its carry is held in a register. The high byte (A) goes second, taking that carry in. A state machine sequences the work through five states:

- `ST_IDLE`: waiting for work.
- `ST_EXEC`: a one-pass operation.
- `ST_WIDE_LO`: the low-byte pass of the 16-bit add.
- `ST_WIDE_HI`: the high-byte pass of the 16-bit add.
- `ST_DONE`: the done pulse.

The transitions are:

| Transition | Condition |
|---|---|
| `ST_IDLE` to `ST_EXEC` | `start` for any opcode except the 16-bit add |
| `ST_IDLE` to `ST_WIDE_LO` | `start` with the 16-bit add opcode |
| `ST_IDLE` to `ST_IDLE` | `ccr_load`; the load takes priority over `start` |
| `ST_WIDE_LO` to `ST_WIDE_HI` | always |
| `ST_EXEC` to `ST_DONE` | always |
| `ST_WIDE_HI` to `ST_DONE` | always |
| `ST_DONE` to `ST_IDLE` | always |

The interrupt-mask and state-saved bits of the condition register are only stored. They change only through the explicit load port.

Top module: `acc_alu_core`

## Requirements
- R1: While `rst_n` is low, and after its release, the outputs are: A=0x00, B=0x00, condition register 0x50 (I and F set), `busy`=0 and `done`=0.
- R2: The condition register bit positions are C=0, V=1, Z=2, N=3, I=4, H=5, F=6, E=7. Opcode 0x00 adds `operand[7:0]` to A and sets C, V, Z, N, and sets H to the carry out of bit 3. Opcode 0x01 subtracts it from A and sets C (borrow), V, Z and N, leaving H unchanged. Codes 0x08 and 0x09 do the same on B.
- R3: Codes 0x02 AND, 0x03 OR and 0x04 XOR combine the accumulator with `operand[7:0]`. Code 0x05 complements the accumulator and ignores the operand. All four set N and Z, clear V, and leave C and H unchanged. Codes 0x0A to 0x0D do the same on B.
- R4: Code 0x06 shifts left and code 0x07 shifts right logically, filling with zero. The bit shifted out goes to C, N and Z follow the result, and V becomes N XOR C. Codes 0x0E and 0x0F do the same on B.
- R5: Code 0x10 writes the unsigned product A*B into A:B, with the high byte in A. Z is set when the full 16-bit product is zero, and C takes product bit 7. The other flags are unchanged.
- R6: Code 0x11 adds `operand[15:0]` to D=A:B in two passes. The carry of the low pass feeds the high pass. Z reflects all 16 result bits, N reflects bit 15, and C and V come from the high pass. H is unchanged.
- R7: `done` is high for exactly one cycle. For a one-pass operation it comes two clock edges after the edge that samples `start`; for the 16-bit add it comes three edges after. `busy` is high from the edge after `start` until `done` falls.
- R8: A `start` while `busy` is high is ignored. In idle, without `start`, A and B hold.
- R9: `ccr_load` in idle writes `ccr_wdata` to all 8 bits and ignores a `start` in the same cycle. `ccr_load` while busy is ignored. ALU operations never alter bits I, F and E.
- R10: Opcodes 0x12 to 0x1F change no register but still give the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled in idle) |
| op_code | input | 5 | Operation select |
| operand | input | 16 | Immediate operand; low byte for 8-bit operations |
| ccr_load | input | 1 | Write the condition register directly |
| ccr_wdata | input | 8 | Value for the condition register load |
| acc_a | output | 8 | Accumulator A (high byte of D) |
| acc_b | output | 8 | Accumulator B (low byte of D) |
| ccr | output | 8 | Condition register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong state of the sequencer shows at the ports as a `done` pulse that comes one cycle early or late, or not at all. The bench counts the cycles of every operation, so such an error is caught within three edges of the `start`. A lost or stale inter-pass carry shows only in the 16-bit add. It appears as a high byte off by one as soon as `done` rises, and the directed cases with a carry out of the low byte expose it. A condition bit written from the wrong source appears in the same cycle as the result. The mask bits are watched across every operation, so any disturbance of them is caught at the next `done`.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    parameter int unsigned ALU_W = 8;

    localparam int CC_C = 0;
    localparam int CC_V = 1;
    localparam int CC_Z = 2;
    localparam int CC_N = 3;
    localparam int CC_I = 4;
    localparam int CC_H = 5;
    localparam int CC_F = 6;
    localparam int CC_E = 7;

    localparam logic [7:0] CCR_RESET = 8'h50;

    localparam logic [4:0] OPC_MUL   = 5'h10;
    localparam logic [4:0] OPC_ADD_D = 5'h11;

    typedef enum logic [2:0] {
        LF_ADD = 3'd0,
        LF_SUB = 3'd1,
        LF_AND = 3'd2,
        LF_OR  = 3'd3,
        LF_XOR = 3'd4,
        LF_COM = 3'd5,
        LF_LSL = 3'd6,
        LF_LSR = 3'd7
    } lane_fn_e;

    typedef enum logic [2:0] {
        FC_NONE,
        FC_ADD,
        FC_SUB,
        FC_LOGIC,
        FC_SHIFT,
        FC_MUL,
        FC_WIDE
    } flag_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXEC,
        ST_WIDE_LO,
        ST_WIDE_HI,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/acc_alu_lane.sv
module acc_alu_lane
    import acc_alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  lane_fn_e       fn,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           c_out,
    output logic           v_out,
    output logic           h_out
);

    logic [W:0] sum_w;
    logic [W:0] dif_w;
    logic [4:0] nib_w;

    assign sum_w = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    assign dif_w = {1'b0, x} - {1'b0, y};
    assign nib_w = {1'b0, x[3:0]} + {1'b0, y[3:0]} + {4'b0, cin};

    always_comb begin
        res   = '0;
        c_out = 1'b0;
        v_out = 1'b0;
        h_out = 1'b0;
        unique case (fn)
            LF_ADD: begin
                res   = sum_w[W-1:0];
                c_out = sum_w[W];
                v_out = (x[W-1] == y[W-1]) && (sum_w[W-1] != x[W-1]);
                h_out = nib_w[4];
            end
            LF_SUB: begin
                res   = dif_w[W-1:0];
                c_out = dif_w[W];
                v_out = (x[W-1] != y[W-1]) && (dif_w[W-1] != x[W-1]);
            end
            LF_AND: res = x & y;
            LF_OR:  res = x | y;
            LF_XOR: res = x ^ y;
            LF_COM: res = ~x;
            LF_LSL: begin
                res   = {x[W-2:0], 1'b0};
                c_out = x[W-1];
            end
            LF_LSR: begin
                res   = {1'b0, x[W-1:1]};
                c_out = x[0];
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/acc_alu_mult.sv
module acc_alu_mult #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] product
);

    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] part [0:W];

    assign part[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_row
        logic [PW-1:0] shifted;
        assign shifted     = {{W{1'b0}}, mcand} << i;
        assign part[i + 1] = part[i] + (mplier[i] ? shifted : '0);
    end

    assign product = part[W];

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
    import acc_alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  flag_cls_e      cls,
    input  logic [2*W-1:0] wide_res,
    input  logic           c_in,
    input  logic           v_in,
    input  logic           h_in,
    input  logic [7:0]     ccr_in,
    output logic [7:0]     ccr_out
);

    logic zero_lo;
    logic neg_lo;
    logic zero_all;

    assign zero_lo  = (wide_res[W-1:0] == '0);
    assign neg_lo   = wide_res[W-1];
    assign zero_all = (wide_res == '0);

    always_comb begin
        ccr_out = ccr_in;
        unique case (cls)
            FC_ADD: begin
                ccr_out[CC_C] = c_in;
                ccr_out[CC_V] = v_in;
                ccr_out[CC_Z] = zero_lo;
                ccr_out[CC_N] = neg_lo;
                ccr_out[CC_H] = h_in;
            end
            FC_SUB: begin
                ccr_out[CC_C] = c_in;
                ccr_out[CC_V] = v_in;
                ccr_out[CC_Z] = zero_lo;
                ccr_out[CC_N] = neg_lo;
            end
            FC_LOGIC: begin
                ccr_out[CC_V] = 1'b0;
                ccr_out[CC_Z] = zero_lo;
                ccr_out[CC_N] = neg_lo;
            end
            FC_SHIFT: begin
                ccr_out[CC_C] = c_in;
                ccr_out[CC_V] = neg_lo ^ c_in;
                ccr_out[CC_Z] = zero_lo;
                ccr_out[CC_N] = neg_lo;
            end
            FC_MUL: begin
                ccr_out[CC_Z] = zero_all;
                ccr_out[CC_C] = wide_res[W-1];
            end
            FC_WIDE: begin
                ccr_out[CC_C] = c_in;
                ccr_out[CC_V] = v_in;
                ccr_out[CC_Z] = zero_all;
                ccr_out[CC_N] = wide_res[2*W-1];
            end
            default: ccr_out = ccr_in;
        endcase
    end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int unsigned W = acc_alu_pkg::ALU_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [4:0]     op_code,
    input  logic [2*W-1:0] operand,
    input  logic           ccr_load,
    input  logic [7:0]     ccr_wdata,
    output logic [W-1:0]   acc_a,
    output logic [W-1:0]   acc_b,
    output logic [7:0]     ccr,
    output logic           busy,
    output logic           done
);

    localparam int unsigned DW = 2 * W;

    seq_state_e     state_q, state_d;
    logic [4:0]     op_q;
    logic [DW-1:0]  opnd_q;
    logic           carry_q;

    lane_fn_e       lane_fn;
    logic [W-1:0]   lane_x, lane_y, lane_res;
    logic           lane_cin, lane_c, lane_v, lane_h;
    logic [DW-1:0]  product;
    flag_cls_e      cls;
    logic [DW-1:0]  flag_src;
    logic [7:0]     ccr_next;
    logic           is_byte_op;
    logic           to_b;

    assign is_byte_op = (op_q[4] == 1'b0);
    assign to_b       = op_q[3];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ccr_load)                     state_d = ST_IDLE;
                else if (start && op_code == OPC_ADD_D) state_d = ST_WIDE_LO;
                else if (start)                   state_d = ST_EXEC;
            end
            ST_EXEC:    state_d = ST_DONE;
            ST_WIDE_LO: state_d = ST_WIDE_HI;
            ST_WIDE_HI: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath steering
    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        lane_fn  = LF_ADD;
        lane_x   = acc_a;
        lane_y   = opnd_q[W-1:0];
        lane_cin = 1'b0;
        cls      = FC_NONE;
        flag_src = {{W{1'b0}}, lane_res};
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_EXEC: begin
                lane_fn = lane_fn_e'(op_q[2:0]);
                lane_x  = to_b ? acc_b : acc_a;
                if (is_byte_op) begin
                    unique case (lane_fn_e'(op_q[2:0]))
                        LF_ADD:                        cls = FC_ADD;
                        LF_SUB:                        cls = FC_SUB;
                        LF_AND, LF_OR, LF_XOR, LF_COM: cls = FC_LOGIC;
                        LF_LSL, LF_LSR:                cls = FC_SHIFT;
                        default:                       cls = FC_NONE;
                    endcase
                end else if (op_q == OPC_MUL) begin
                    cls      = FC_MUL;
                    flag_src = product;
                end
            end
            ST_WIDE_LO: begin
                lane_x = acc_b;
                lane_y = opnd_q[W-1:0];
            end
            ST_WIDE_HI: begin
                lane_x   = acc_a;
                lane_y   = opnd_q[DW-1:W];
                lane_cin = carry_q;
                cls      = FC_WIDE;
                flag_src = {lane_res, acc_b};
            end
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    acc_alu_lane #(.W(W)) u_lane (
        .fn    (lane_fn),
        .x     (lane_x),
        .y     (lane_y),
        .cin   (lane_cin),
        .res   (lane_res),
        .c_out (lane_c),
        .v_out (lane_v),
        .h_out (lane_h)
    );

    acc_alu_mult #(.W(W)) u_mult (
        .mcand   (acc_a),
        .mplier  (acc_b),
        .product (product)
    );

    acc_alu_flags #(.W(W)) u_flags (
        .cls      (cls),
        .wide_res (flag_src),
        .c_in     (lane_c),
        .v_in     (lane_v),
        .h_in     (lane_h),
        .ccr_in   (ccr),
        .ccr_out  (ccr_next)
    );

    // register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_a   <= '0;
            acc_b   <= '0;
            ccr     <= CCR_RESET;
            op_q    <= '0;
            opnd_q  <= '0;
            carry_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ccr_load) begin
                        ccr <= ccr_wdata;
                    end else if (start) begin
                        op_q   <= op_code;
                        opnd_q <= operand;
                    end
                end
                ST_EXEC: begin
                    if (is_byte_op) begin
                        if (to_b) acc_b <= lane_res;
                        else      acc_a <= lane_res;
                        ccr <= ccr_next;
                    end else if (op_q == OPC_MUL) begin
                        acc_a <= product[DW-1:W];
                        acc_b <= product[W-1:0];
                        ccr   <= ccr_next;
                    end
                end
                ST_WIDE_LO: begin
                    acc_b   <= lane_res;
                    carry_q <= lane_c;
                end
                ST_WIDE_HI: begin
                    acc_a <= lane_res;
                    ccr   <= ccr_next;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/acc_alu_core_chk.sv
module acc_alu_core_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         ccr_load,
    input logic [W-1:0] acc_a,
    input logic [W-1:0] acc_b,
    input logic [7:0]   ccr,
    input logic         busy,
    input logic         done
);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r7_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !ccr_load) |=> busy);

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(acc_a) && $stable(acc_b)));

    a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ccr_load |=> $stable({ccr[7], ccr[6], ccr[4]}));

endmodule

bind acc_alu_core acc_alu_core_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ccr_load (ccr_load),
    .acc_a    (acc_a),
    .acc_b    (acc_b),
    .ccr      (ccr),
    .busy     (busy),
    .done     (done)
);

// File: tb/acc_alu_core_tb.sv
module acc_alu_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  op_code = '0;
    logic [15:0] operand = '0;
    logic        ccr_load = 1'b0;
    logic [7:0]  ccr_wdata = '0;
    logic [7:0]  acc_a, acc_b, ccr;
    logic        busy, done;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    acc_alu_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_code   (op_code),
        .operand   (operand),
        .ccr_load  (ccr_load),
        .ccr_wdata (ccr_wdata),
        .acc_a     (acc_a),
        .acc_b     (acc_b),
        .ccr       (ccr),
        .busy      (busy),
        .done      (done)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [4:0] o, input logic [15:0] d, output int cyc);
        @(negedge clk);
        op_code = o; operand = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic load_ccr(input logic [7:0] v);
        @(negedge clk);
        ccr_load = 1'b1; ccr_wdata = v;
        @(negedge clk);
        ccr_load = 1'b0;
    endtask

    task automatic op8(input string req, input logic [4:0] o, input logic [7:0] d,
                       input logic [7:0] ea, input logic [7:0] eb, input logic [7:0] ec);
        int cyc;
        issue(o, {8'h00, d}, cyc);
        chk({req, " cycles"}, 16'(cyc), 16'd2);
        chk({req, " A"}, {8'h00, acc_a}, {8'h00, ea});
        chk({req, " B"}, {8'h00, acc_b}, {8'h00, eb});
        chk({req, " CCR"}, {8'h00, ccr}, {8'h00, ec});
    endtask

    task automatic t_reset;
        chk("R1 A", {8'h00, acc_a}, 16'h0000);
        chk("R1 B", {8'h00, acc_b}, 16'h0000);
        chk("R1 CCR", {8'h00, ccr}, 16'h0050);
        chk("R1 busy/done", {14'h0, busy, done}, 16'h0000);
    endtask

    task automatic t_addsub;
        load_ccr(8'h00);
        op8("R2 add", 5'h00, 8'h7F, 8'h7F, 8'h00, 8'h00);
        op8("R2 add half/ovf", 5'h00, 8'h01, 8'h80, 8'h00, 8'h2A);
        op8("R2 add carry/zero", 5'h00, 8'h80, 8'h00, 8'h00, 8'h07);
        op8("R2 sub borrow", 5'h01, 8'h01, 8'hFF, 8'h00, 8'h09);
        op8("R2 sub zero", 5'h01, 8'hFF, 8'h00, 8'h00, 8'h04);
    endtask

    task automatic t_logic;
        load_ccr(8'h03);
        op8("R3 or", 5'h03, 8'hF0, 8'hF0, 8'h00, 8'h09);
        op8("R3 and", 5'h02, 8'h0F, 8'h00, 8'h00, 8'h05);
        op8("R3 xor", 5'h04, 8'h5A, 8'h5A, 8'h00, 8'h01);
        op8("R3 com", 5'h05, 8'h33, 8'hA5, 8'h00, 8'h09);
    endtask

    task automatic t_shift;
        op8("R4 lsl", 5'h06, 8'h00, 8'h4A, 8'h00, 8'h03);
        op8("R4 lsr", 5'h07, 8'h00, 8'h25, 8'h00, 8'h00);
        op8("R4 lsr out1", 5'h07, 8'h00, 8'h12, 8'h00, 8'h03);
        op8("R2 add to B", 5'h08, 8'h30, 8'h12, 8'h30, 8'h00);
    endtask

    task automatic t_mul;
        op8("R5 mul", 5'h10, 8'h00, 8'h03, 8'h60, 8'h00);
        op8("R5 setup", 5'h02, 8'h00, 8'h00, 8'h60, 8'h04);
        op8("R5 setup", 5'h00, 8'h0B, 8'h0B, 8'h60, 8'h00);
        op8("R5 setup", 5'h0A, 8'h00, 8'h0B, 8'h00, 8'h04);
        op8("R5 setup", 5'h08, 8'h0D, 8'h0B, 8'h0D, 8'h00);
        op8("R5 mul bit7", 5'h10, 8'h00, 8'h00, 8'h8F, 8'h01);
        op8("R5 mul zero", 5'h10, 8'h00, 8'h00, 8'h00, 8'h04);
    endtask

    task automatic wide(input string req, input logic [15:0] d,
                        input logic [15:0] ed, input logic [7:0] ec);
        int cyc;
        issue(5'h11, d, cyc);
        chk({req, " cycles"}, 16'(cyc), 16'd3);
        chk({req, " D"}, {acc_a, acc_b}, ed);
        chk({req, " CCR"}, {8'h00, ccr}, {8'h00, ec});
    endtask

    task automatic t_wide;
        op8("R6 setup", 5'h00, 8'h12, 8'h12, 8'h00, 8'h00);
        op8("R6 setup", 5'h08, 8'hF0, 8'h12, 8'hF0, 8'h08);
        load_ccr(8'h00);
        wide("R6 carry between passes", 16'h0110, 16'h1400, 8'h00);
        wide("R6 carry/zero", 16'hEC00, 16'h0000, 8'h05);
        wide("R6 plain", 16'h7FFF, 16'h7FFF, 8'h00);
        wide("R6 overflow", 16'h0001, 16'h8000, 8'h0A);
    endtask

    task automatic t_undef;
        op8("R10 undefined", 5'h1F, 8'hFF, 8'h80, 8'h00, 8'h0A);
    endtask

    task automatic t_busy;
        @(negedge clk);
        op_code = 5'h00; operand = 16'h0001; start = 1'b1;
        @(negedge clk);
        chk("R7 busy after start", {15'h0, busy}, 16'h0001);
        op_code = 5'h00; operand = 16'h0010; start = 1'b1;
        ccr_load = 1'b1; ccr_wdata = 8'hFF;
        @(negedge clk);
        chk("R7 done pulse", {15'h0, done}, 16'h0001);
        @(negedge clk);
        start = 1'b0; ccr_load = 1'b0;
        chk("R7 done single", {15'h0, done}, 16'h0000);
        repeat (3) @(negedge clk);
        chk("R8 start ignored A", {8'h00, acc_a}, 16'h0081);
        chk("R9 load ignored busy", {8'h00, ccr}, 16'h0008);
        chk("R8 idle", {14'h0, busy, done}, 16'h0000);
    endtask

    task automatic t_ccr;
        @(negedge clk);
        ccr_load = 1'b1; ccr_wdata = 8'hD0;
        start = 1'b1; op_code = 5'h00; operand = 16'h0001;
        @(negedge clk);
        ccr_load = 1'b0; start = 1'b0;
        chk("R9 load value", {8'h00, ccr}, 16'h00D0);
        repeat (3) @(negedge clk);
        chk("R9 start dropped", {8'h00, acc_a}, 16'h0081);
        op8("R9 masks held", 5'h00, 8'h7F, 8'h00, 8'h00, 8'hF5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addsub();
        t_logic();
        t_shift();
        t_mul();
        t_wide();
        t_undef();
        t_busy();
        t_ccr();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule